// File: doc/BRIEF.md
# Eight-Channel GPIO Pin Interrupt Generator

This block watches a set of GPIO input pins, eight by default, and gives each pin its own interrupt output line. Channel n always drives output n. Each channel is either edge-sensitive or level-sensitive. In edge mode it can fire on a rising edge, a falling edge or both. In level mode it can be active-high or active-low. Each pin passes through a two-stage synchroniser. Edges are found by comparing the synchronised value with the value it had one cycle earlier.

Software reaches the block through a plain 32-bit register port: address, write strobe, write data and combinational read data. The two enable vectors cannot be written directly. Each is changed through a set register and a clear register, so one channel can be reconfigured without a read-modify-write. In edge mode, a detected edge is held in a status bit until software writes a one to that bit. In level mode the output follows the qualified pin level with no latch, the rising enable acts as the channel enable and the falling enable selects polarity.

Top module: `gpio_pin_irq`

## Requirements
- R1: After reset the mode, rising-enable, falling-enable and status vectors are all zero and every interrupt output is low.
- R2: Offset 0x000 holds the mode vector: bit n = 1 puts channel n in level mode, 0 in edge mode. It is written directly and reads back its low N_CH bits; higher data bits are dropped.
- R3: Writing ones to offset 0x008 sets rising-enable bits and writing ones to 0x00C clears them. Zero data bits leave a bit unchanged. Both offsets read back the rising-enable vector.
- R4: Writing ones to offset 0x014 sets falling-enable bits and writing ones to 0x018 clears them. Zero data bits leave a bit unchanged. Both offsets read back the falling-enable vector.
- R5: In edge mode, a low-to-high pin change sets status bit n when the channel's rising enable is 1, and a high-to-low change sets it when the falling enable is 1. With both enables set, either direction sets it. With neither set, nothing is latched.
- R6: Offset 0x024 reads the status vector. Writing a 1 to bit n clears it and writing a 0 leaves it alone. An edge-mode output is high exactly while its status bit is set.
- R7: In level mode, output n is high when rising enable n is 1 and the synchronised pin equals falling enable n (1 = active-high, 0 = active-low). It drops as soon as that condition fails, and level-mode pin changes never set status.
- R8: When an edge is detected in the same cycle as a clearing write to its status bit, the bit stays set.
- R9: A pin change sets its status bit on the third rising clock edge after the change and not earlier.
- R10: Any other offset reads as zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| pin_i | input | N_CH (8) | Asynchronous GPIO pin inputs |
| bus_addr | input | AW (12) | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| irq_o | output | N_CH (8) | One interrupt line per channel |

## Verification
Directed sequences place a single rising edge, then a single falling edge, on channels set for rising only, falling only and both. This separates the two edge comparisons and shows that an enable left at zero blocks latching. Level-mode runs flip the polarity bit while the pin is held steady, so an output driven by the live level can be told apart from one latched on an edge. A clear write timed to land in the same cycle as a new edge tells edge-wins priority apart from clear-wins. Random pin patterns mixed with random set, clear, mode and unmapped writes then compare every output and read-back against a bench model.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
    // Register byte offsets; software depends on these values.
    localparam int unsigned OFS_MODE   = 32'h000;
    localparam int unsigned OFS_RISE_S = 32'h008;
    localparam int unsigned OFS_RISE_C = 32'h00C;
    localparam int unsigned OFS_FALL_S = 32'h014;
    localparam int unsigned OFS_FALL_C = 32'h018;
    localparam int unsigned OFS_STAT   = 32'h024;
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pin_i,
    output logic [N_CH-1:0] sync_q,
    output logic [N_CH-1:0] prev_q
);
    typedef struct packed {
        logic [N_CH-1:0] meta;
        logic [N_CH-1:0] sync;
        logic [N_CH-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_q = st_q.sync;
    assign prev_q = st_q.prev;
endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
    import pinirq_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int AW   = 12,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [N_CH-1:0] stat_q,
    output logic [N_CH-1:0] stat_clr,
    output logic [N_CH-1:0] mode_q,
    output logic [N_CH-1:0] rise_q,
    output logic [N_CH-1:0] fall_q
);
    localparam logic [AW-1:0] A_MODE   = AW'(OFS_MODE);
    localparam logic [AW-1:0] A_RISE_S = AW'(OFS_RISE_S);
    localparam logic [AW-1:0] A_RISE_C = AW'(OFS_RISE_C);
    localparam logic [AW-1:0] A_FALL_S = AW'(OFS_FALL_S);
    localparam logic [AW-1:0] A_FALL_C = AW'(OFS_FALL_C);
    localparam logic [AW-1:0] A_STAT   = AW'(OFS_STAT);

    typedef struct packed {
        logic [N_CH-1:0] mode;
        logic [N_CH-1:0] rise;
        logic [N_CH-1:0] fall;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [N_CH-1:0] wd;
    logic            unused_wdata_hi;

    assign wd              = bus_wdata[N_CH-1:0];
    assign unused_wdata_hi = ^bus_wdata[DW-1:N_CH];

    always_comb begin
        cfg_d    = cfg_q;
        stat_clr = '0;
        if (bus_we) begin
            unique case (bus_addr)
                A_MODE:   cfg_d.mode = wd;
                A_RISE_S: cfg_d.rise = cfg_q.rise | wd;
                A_RISE_C: cfg_d.rise = cfg_q.rise & ~wd;
                A_FALL_S: cfg_d.fall = cfg_q.fall | wd;
                A_FALL_C: cfg_d.fall = cfg_q.fall & ~wd;
                A_STAT:   stat_clr   = wd;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        unique case (bus_addr)
            A_MODE:             bus_rdata = DW'(cfg_q.mode);
            A_RISE_S, A_RISE_C: bus_rdata = DW'(cfg_q.rise);
            A_FALL_S, A_FALL_C: bus_rdata = DW'(cfg_q.fall);
            A_STAT:             bus_rdata = DW'(stat_q);
            default:            bus_rdata = '0;
        endcase
    end

    assign mode_q = cfg_q.mode;
    assign rise_q = cfg_q.rise;
    assign fall_q = cfg_q.fall;
endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] sync_q,
    input  logic [N_CH-1:0] prev_q,
    input  logic [N_CH-1:0] mode_q,
    input  logic [N_CH-1:0] rise_q,
    input  logic [N_CH-1:0] fall_q,
    input  logic [N_CH-1:0] stat_clr,
    output logic [N_CH-1:0] stat_q,
    output logic [N_CH-1:0] irq_o
);
    typedef struct packed {
        logic [N_CH-1:0] stat;
    } det_t;

    det_t dt_d, dt_q;
    logic [N_CH-1:0] hit_up, hit_dn, lvl_act;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        // Edge mode: compare current synchronised level with last cycle's.
        assign hit_up[i]  = ~mode_q[i] & rise_q[i] &  sync_q[i] & ~prev_q[i];
        assign hit_dn[i]  = ~mode_q[i] & fall_q[i] & ~sync_q[i] &  prev_q[i];
        // Level mode: rise enable gates, fall enable picks the active level.
        assign lvl_act[i] =  mode_q[i] & rise_q[i] & (sync_q[i] ~^ fall_q[i]);
        assign irq_o[i]   = mode_q[i] ? lvl_act[i] : dt_q.stat[i];
    end

    always_comb begin
        dt_d      = dt_q;
        // A new edge overrides a clear landing in the same cycle.
        dt_d.stat = (dt_q.stat & ~stat_clr) | hit_up | hit_dn;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dt_q <= '0;
        else        dt_q <= dt_d;
    end

    assign stat_q = dt_q.stat;
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq #(
    parameter int N_CH = 8,
    parameter int AW   = 12,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pin_i,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [N_CH-1:0] irq_o
);
    logic [N_CH-1:0] sync_q, prev_q;
    logic [N_CH-1:0] mode_q, rise_q, fall_q;
    logic [N_CH-1:0] stat_q, stat_clr;

    pinirq_sync #(.N_CH(N_CH)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .sync_q (sync_q),
        .prev_q (prev_q)
    );

    pinirq_regs #(.N_CH(N_CH), .AW(AW), .DW(DW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stat_q    (stat_q),
        .stat_clr  (stat_clr),
        .mode_q    (mode_q),
        .rise_q    (rise_q),
        .fall_q    (fall_q)
    );

    pinirq_detect #(.N_CH(N_CH)) det_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_q   (sync_q),
        .prev_q   (prev_q),
        .mode_q   (mode_q),
        .rise_q   (rise_q),
        .fall_q   (fall_q),
        .stat_clr (stat_clr),
        .stat_q   (stat_q),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/pinirq_checker.sv
module pinirq_checker
    import pinirq_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int AW   = 12,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_we,
    input logic [DW-1:0]   bus_wdata,
    input logic [N_CH-1:0] irq_o,
    input logic [N_CH-1:0] mode_q,
    input logic [N_CH-1:0] rise_q,
    input logic [N_CH-1:0] fall_q,
    input logic [N_CH-1:0] stat_q,
    input logic [N_CH-1:0] sync_q,
    input logic [N_CH-1:0] prev_q
);
    logic [N_CH-1:0] wd;
    logic [N_CH-1:0] up_seen;
    assign wd      = bus_wdata[N_CH-1:0];
    assign up_seen = ~mode_q & rise_q & sync_q & ~prev_q;

    a_r3_rise_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFS_RISE_S)) |=> ((rise_q & $past(wd)) == $past(wd)));

    a_r3_rise_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFS_RISE_C)) |=> ((rise_q & $past(wd)) == '0));

    a_r4_fall_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFS_FALL_S)) |=> ((fall_q & $past(wd)) == $past(wd)));

    a_r4_fall_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFS_FALL_C)) |=> ((fall_q & $past(wd)) == '0));

    // R5 and R8: an enabled rising edge always leaves its flag set, clear or not.
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (up_seen != '0) |=> ((stat_q & $past(up_seen)) == $past(up_seen)));

    // R5: a flag only appears after a pin transition.
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(sync_q ^ prev_q)) == '0));

    a_r6_edge_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~mode_q) == (stat_q & ~mode_q)));

    a_r7_level_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & mode_q & ~rise_q) == '0));
endmodule

bind gpio_pin_irq pinirq_checker #(.N_CH(N_CH), .AW(AW), .DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .mode_q    (mode_q),
    .rise_q    (rise_q),
    .fall_q    (fall_q),
    .stat_q    (stat_q),
    .sync_q    (sync_q),
    .prev_q    (prev_q)
);

// File: tb/gpio_pin_irq_tb_top.sv
`timescale 1ns/1ps
module gpio_pin_irq_tb_top;
    localparam int N  = 8;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_i = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench model
    logic [N-1:0] m_mode = '0, m_rise = '0, m_fall = '0, m_stat = '0, m_pin = '0;

    always #2 clk = ~clk;

    gpio_pin_irq #(.N_CH(N), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [N-1:0] exp_irq();
        logic [N-1:0] lvl;
        lvl = m_mode & m_rise & ~(m_pin ^ m_fall);
        return (m_mode & lvl) | (~m_mode & m_stat);
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        case (a)
            12'h000:          return DW'(m_mode);
            12'h008, 12'h00C: return DW'(m_rise);
            12'h014, 12'h018: return DW'(m_fall);
            12'h024:          return DW'(m_stat);
            default:          return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Starts and ends at a negedge.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [N-1:0] w;
        w = d[N-1:0];
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            12'h000: m_mode = w;
            12'h008: m_rise = m_rise | w;
            12'h00C: m_rise = m_rise & ~w;
            12'h014: m_fall = m_fall | w;
            12'h018: m_fall = m_fall & ~w;
            12'h024: m_stat = m_stat & ~w;
            default: ;
        endcase
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_read(a));
    endtask

    task automatic model_pins(input logic [N-1:0] v);
        logic [N-1:0] up, dn;
        up = v & ~m_pin & m_rise & ~m_mode;
        dn = ~v & m_pin & m_fall & ~m_mode;
        m_stat = m_stat | up | dn;
        m_pin = v;
    endtask

    task automatic set_pins(input logic [N-1:0] v);
        pin_i = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_pins(v);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] addrs [7];
        void'($urandom(32'd2024));
        addrs = '{12'h000, 12'h008, 12'h00C, 12'h014, 12'h018, 12'h024, 12'h030};
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", DW'(irq_o), '0);
        rd_chk("R1 mode", 12'h000);
        rd_chk("R1 rise", 12'h008);
        rd_chk("R1 fall", 12'h014);
        rd_chk("R1 stat", 12'h024);

        // R2: mode register, high bits dropped
        wr(12'h000, 32'hFFFF_FFA5);
        chk("R2 mode readback", bus_rdata, 32'h0000_00A5);
        wr(12'h000, 32'h0);
        rd_chk("R2 mode cleared", 12'h000);

        // R3: rising set/clear
        wr(12'h008, 32'h0F);
        wr(12'h008, 32'h30);
        chk("R3 set keeps others", bus_rdata, 32'h3F);
        wr(12'h00C, 32'h05);
        chk("R3 clear alias", bus_rdata, 32'h3A);
        wr(12'h00C, 32'hFF);
        rd_chk("R3 cleared", 12'h008);

        // R4: falling set/clear
        wr(12'h014, 32'hC0);
        wr(12'h014, 32'h03);
        chk("R4 set keeps others", bus_rdata, 32'hC3);
        wr(12'h018, 32'h41);
        chk("R4 clear alias", bus_rdata, 32'h82);
        wr(12'h018, 32'hFF);
        rd_chk("R4 cleared", 12'h014);

        // R10: unmapped offset
        wr(12'h008, 32'h11);
        wr(12'h004, 32'hFFFF_FFFF);
        chk("R10 unmapped reads zero", bus_rdata, '0);
        rd_chk("R10 rise untouched", 12'h008);
        rd_chk("R10 mode untouched", 12'h000);
        wr(12'h00C, 32'hFF);

        // R9: latency of a rising edge on channel 0
        wr(12'h008, 32'h01);
        pin_i = 8'h01;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_addr = 12'h024; #1;
        chk("R9 not yet latched", bus_rdata, '0);
        @(posedge clk);
        @(negedge clk);
        model_pins(8'h01);
        rd_chk("R9 latched on third edge", 12'h024);
        chk("R6 edge irq high", DW'(irq_o), 32'h01);

        // R6: W1C
        wr(12'h024, 32'h02);
        chk("R6 zero bits keep flag", bus_rdata, 32'h01);
        wr(12'h024, 32'h01);
        chk("R6 cleared", bus_rdata, '0);
        chk("R6 irq low", DW'(irq_o), '0);

        // R5: falling only, both, none
        set_pins(8'h00);
        chk("R5 falling blocked", DW'(irq_o), '0);
        wr(12'h014, 32'h02);
        wr(12'h008, 32'h04);
        wr(12'h014, 32'h04);
        set_pins(8'h06);
        chk("R5 rise on both-enabled", DW'(irq_o), 32'h04);
        wr(12'h024, 32'hFF);
        set_pins(8'h00);
        chk("R5 fall on both and fall-only", DW'(irq_o), 32'h06);
        set_pins(8'h08);
        chk("R5 no enable no latch", DW'(irq_o), DW'(exp_irq()));
        wr(12'h024, 32'hFF);

        // R8: clear and edge in the same cycle
        set_pins(8'h00);
        pin_i = 8'h01;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_addr = 12'h024; bus_wdata = 32'h01; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        m_pin = 8'h01;
        m_stat = m_stat | 8'h01;
        #1;
        chk("R8 edge wins", bus_rdata, 32'h01);
        wr(12'h024, 32'hFF);

        // R7: level mode on channel 1
        wr(12'h00C, 32'hFF);
        wr(12'h018, 32'hFF);
        wr(12'h000, 32'h02);
        wr(12'h008, 32'h02);
        wr(12'h014, 32'h02);
        set_pins(8'h02);
        chk("R7 active high", DW'(irq_o), 32'h02);
        set_pins(8'h00);
        chk("R7 drops without latch", DW'(irq_o), '0);
        rd_chk("R7 no status", 12'h024);
        wr(12'h018, 32'h02);
        chk("R7 active low", DW'(irq_o), 32'h02);
        wr(12'h00C, 32'h02);
        chk("R7 disabled", DW'(irq_o), '0);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(1, 0) == 0)
                set_pins(N'($urandom()));
            else
                wr(addrs[$urandom_range(6, 0)], $urandom());
            chk("R5/R6/R7 random irq", DW'(irq_o), DW'(exp_irq()));
            rd_chk("R2/R3/R4/R10 random read", addrs[$urandom_range(6, 0)]);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule